// File: doc/BRIEF.md
# Charge-Balance Recovery Time Calculator

This block sits between a peak/valley detector and a switching-sequence generator in a fast-recovery controller for a step-down converter. When the detector reports the extreme point of an output-voltage excursion, the block turns that event into two durations for one recovery switching cycle, both counted in delay-line ticks. The first is the on duration and the second is the off duration. The inputs are the deviation magnitude in quantizer steps, the interval the detector measured between the last two quantizer transitions, and the polarity of the excursion. The computation never needs the converter input voltage.

The block keeps its own estimate of the steady-state duty ratio by low-pass filtering the duty commands of the regulation loop. Half of the measured interval is taken as the detection delay. A fractional index derived from that delay refines the coarse deviation code, and the refined code addresses a square-root table. The table value is scaled by D and by 1−D to give the two durations. The estimated delay is then taken off the on duration. The durations and the switching order reach the outputs on a single-cycle strobe.

Top module: `recov_time_calc`

## Requirements
- R1: After reset, res_vld, on_first, on_cnt and off_cnt are all 0, and the duty estimate D holds DINIT (128 by default).
- R2: det_stb high in cycle c makes res_vld high for exactly one cycle, in cycle c+2.
- R3: On each cycle with duty_upd high, D becomes D + floor((duty_cmd − D)/16). Without duty_upd, D is unchanged and a new duty_cmd has no effect on later results.
- R4: The detection delay estimate is E = floor(band_ticks/2). The table index is dev_code·4 + min(floor(E/4), 3), with dev_code in the upper bits and the fraction in the two low bits.
- R5: Table entry L at index i is floor(sqrt(i·4096)).
- R6: off_cnt is floor(L·(256−D)/256), and the uncorrected on time is floor(L·D/256). D is sampled in the cycle det_stb is high, so a duty_upd in that same cycle affects only later detections.
- R7: on_cnt is the uncorrected on time minus E. When E is larger, on_cnt is 0.
- R8: Both counts saturate at 255 (2^TW−1).
- R9: on_first equals the dip input captured with det_stb: 1 means the on duration comes first (output dip) and 0 means the off duration comes first (overshoot). The counts do not depend on dip.
- R10: on_cnt, off_cnt and on_first keep their values between result strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_cmd | input | 8 | Duty command from the regulation loop (fraction of 256) |
| duty_upd | input | 1 | Strobe that feeds duty_cmd into the filter |
| det_stb | input | 1 | Extreme-point detection strobe |
| dip | input | 1 | Excursion polarity: 1 = dip, 0 = overshoot |
| dev_code | input | 4 | Deviation magnitude in quantizer steps |
| band_ticks | input | 8 | Measured band interval in delay ticks |
| res_vld | output | 1 | Result strobe |
| on_first | output | 1 | 1 when the on duration is applied first |
| on_cnt | output | 8 | On duration in ticks |
| off_cnt | output | 8 | Off duration in ticks |

## Verification
The bench targets the clamp of the on duration when the delay estimate exceeds it; a design that wraps instead would output a huge count. It drives deviations large enough to saturate, where a design without saturation would output a truncated small count. It also drives a duty update in the same cycle as a detection; a design that reads the filter after its update would shift both durations. Further cases are the index fraction at its ceiling, the negative filter step (floor rounding), and duty commands sent without the update strobe, which a careless design would fold into the estimate.

// File: rtl/recov_time_calc.sv
module recov_time_calc #(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int FB = 2,
  parameter int BW = 8,
  parameter int TW = 8,
  parameter int QSH = 2,
  parameter int LPF_SH = 4,
  parameter int GAIN_SQ = 4096,
  parameter int DINIT = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty_cmd,
  input  logic          duty_upd,
  input  logic          det_stb,
  input  logic          dip,
  input  logic [CW-1:0] dev_code,
  input  logic [BW-1:0] band_ticks,
  output logic          res_vld,
  output logic          on_first,
  output logic [TW-1:0] on_cnt,
  output logic [TW-1:0] off_cnt
);

  function automatic int unsigned isqrt(int unsigned v);
    int unsigned r;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      int unsigned t;
      t = r | (32'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  localparam int IW    = CW + FB;
  localparam int DEPTH = 2 ** IW;
  localparam int LMAX  = isqrt((DEPTH - 1) * GAIN_SQ);
  localparam int LW    = $clog2(LMAX + 1);
  localparam int PW    = LW + DW + 1;
  localparam int FMAX  = 2 ** FB - 1;
  localparam int TMAX  = 2 ** TW - 1;

  logic [LW-1:0] lut [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_lut
    assign lut[i] = LW'(isqrt(i * GAIN_SQ));
  end

  logic [DW-1:0] d_est;
  logic signed [DW+1:0] d_diff, d_step;
  assign d_diff = $signed({2'b00, duty_cmd}) - $signed({2'b00, d_est});
  assign d_step = d_diff >>> LPF_SH;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) d_est <= DW'(DINIT);
    else if (duty_upd) d_est <= d_est + d_step[DW-1:0];

  logic [BW-1:0] est_dly, q_raw;
  logic [FB-1:0] q_frac;
  logic [IW-1:0] lut_idx;
  assign est_dly = band_ticks >> 1;
  assign q_raw   = est_dly >> QSH;
  assign q_frac  = (q_raw > BW'(FMAX)) ? FB'(FMAX) : q_raw[FB-1:0];
  assign lut_idx = {dev_code, q_frac};

  logic          s1_vld, s1_dip;
  logic [LW-1:0] s1_lut;
  logic [BW-1:0] s1_dly;
  logic [DW-1:0] s1_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_dip <= 1'b0;
      s1_lut <= '0;
      s1_dly <= '0;
      s1_d   <= '0;
    end else begin
      s1_vld <= det_stb;
      if (det_stb) begin
        s1_dip <= dip;
        s1_lut <= lut[lut_idx];
        s1_dly <= est_dly;
        s1_d   <= d_est;
      end
    end

  logic [PW-1:0] p_on, p_off, on_full, off_full, on_corr;
  assign p_on     = PW'(s1_lut) * PW'(s1_d);
  assign p_off    = PW'(s1_lut) * (PW'(2 ** DW) - PW'(s1_d));
  assign on_full  = p_on >> DW;
  assign off_full = p_off >> DW;
  assign on_corr  = (on_full > PW'(s1_dly)) ? on_full - PW'(s1_dly) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_vld  <= 1'b0;
      on_first <= 1'b0;
      on_cnt   <= '0;
      off_cnt  <= '0;
    end else begin
      res_vld <= s1_vld;
      if (s1_vld) begin
        on_first <= s1_dip;
        on_cnt   <= (on_corr > PW'(TMAX)) ? TW'(TMAX) : on_corr[TW-1:0];
        off_cnt  <= (off_full > PW'(TMAX)) ? TW'(TMAX) : off_full[TW-1:0];
      end
    end

  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    det_stb |-> ##2 res_vld);
  p_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_stb |-> ##2 (on_first == $past(dip, 2)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_upd |=> $stable(d_est));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_upd && duty_cmd >= d_est) |=> (d_est >= $past(d_est) && d_est <= $past(duty_cmd)));
  p_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(on_cnt) && $stable(off_cnt) && $stable(on_first)));

endmodule

// File: tb/recov_time_calc_tb_top.sv
module recov_time_calc_tb_top;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] duty_cmd = '0, band_ticks = '0;
  logic duty_upd = 1'b0, det_stb = 1'b0, dip = 1'b0;
  logic [3:0] dev_code = '0;
  logic res_vld, on_first;
  logic [7:0] on_cnt, off_cnt;

  always #(PER/2) clk = ~clk;

  recov_time_calc dut_i (.clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .duty_upd(duty_upd),
    .det_stb(det_stb), .dip(dip), .dev_code(dev_code), .band_ticks(band_ticks),
    .res_vld(res_vld), .on_first(on_first), .on_cnt(on_cnt), .off_cnt(off_cnt));

  int errs = 0, chks = 0, cyc = 0, d_mdl = 128;
  bit done = 0;
  int q_on[$], q_off[$], q_first[$], q_cyc[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sq(int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic upd_model(int cmd);
    int diff = cmd - d_mdl;
    d_mdl = d_mdl + (diff >>> 4);
  endtask

  task automatic fire(int dev, int band, bit pol, bit with_upd, int cmd);
    int e, fr, idx, l, onr, on, off;
    e = band / 2;
    fr = (e / 4 > 3) ? 3 : e / 4;
    idx = dev * 4 + fr;
    l = sq(idx * 4096);
    onr = (l * d_mdl) / 256;
    off = (l * (256 - d_mdl)) / 256;
    on = (onr > e) ? onr - e : 0;
    if (on > 255) on = 255;
    if (off > 255) off = 255;
    q_on.push_back(on); q_off.push_back(off); q_first.push_back(pol); q_cyc.push_back(cyc + 2);
    dev_code = dev[3:0]; band_ticks = band[7:0]; dip = pol; det_stb = 1'b1;
    if (with_upd) begin duty_cmd = cmd[7:0]; duty_upd = 1'b1; end
    @(negedge clk);
    det_stb = 1'b0; duty_upd = 1'b0;
    if (with_upd) upd_model(cmd);
  endtask

  task automatic duty(int cmd);
    duty_cmd = cmd[7:0]; duty_upd = 1'b1;
    @(negedge clk);
    duty_upd = 1'b0;
    upd_model(cmd);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (res_vld) begin
      if (q_on.size() == 0) check("R2 unexpected strobe", 1, 0);
      else begin
        check("R2 latency", cyc, q_cyc.pop_front());
        check("R6/R7/R8 on_cnt", on_cnt, q_on.pop_front());
        check("R6/R8 off_cnt", off_cnt, q_off.pop_front());
        check("R9 on_first", on_first, q_first.pop_front());
      end
    end else if (q_cyc.size() != 0 && cyc > q_cyc[0]) begin
      check("R2 missing strobe", 0, 1);
      void'(q_cyc.pop_front()); void'(q_on.pop_front());
      void'(q_off.pop_front()); void'(q_first.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  endtask

  initial begin
    #(PER * 100000);
    check("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] h_on, h_off;
    repeat (3) @(negedge clk);
    check("R1 res_vld", res_vld, 0);
    check("R1 on_cnt", on_cnt, 0);
    check("R1 off_cnt", off_cnt, 0);
    check("R1 on_first", on_first, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R4/R5: default D=128, index 22
    fire(5, 20, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R9: polarity reversal, same counts
    fire(5, 20, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R10: outputs hold
    h_on = on_cnt; h_off = off_cnt;
    repeat (4) @(negedge clk);
    check("R10 hold on", on_cnt, h_on);
    check("R10 hold off", off_cnt, h_off);
    check("R10 strobe low", res_vld, 0);
    // R3: upward and downward (floor) steps
    duty(200);
    duty(0);
    fire(9, 8, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R3: command without strobe ignored
    duty_cmd = 8'd255;
    repeat (2) @(negedge clk);
    fire(9, 8, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R4: fraction ceiling
    fire(3, 60, 1'b0, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R7: clamp to zero
    fire(1, 255, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R8: saturation
    for (int k = 0; k < 8; k++) duty(250);
    fire(15, 0, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // R6: duty update in the detection cycle uses old D
    fire(7, 12, 1'b0, 1'b1, 10);
    repeat (3) @(negedge clk);
    fire(7, 12, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    // back-to-back detections
    fire(2, 4, 1'b1, 1'b0, 0);
    fire(12, 30, 1'b0, 1'b0, 0);
    fire(0, 2, 1'b1, 1'b0, 0);
    repeat (4) @(negedge clk);
    check("R2 all results seen", q_on.size(), 0);
    finish_run();
  end
endmodule